// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers edge events from many peripheral sources into 32-bit source sets and presents two request lines to a processor. A fixed subset of sources is hard-wired to priority levels 1 to 15. Those sources skip the per-bit enables and feed a priority encoder gated by a per-level mask. The winning level is shown on a 4-bit vector and drives the high request line. Every other source that is pending and enabled merges onto a single low request line with no priority among its sources. Software reads status, clears pending bits by writing ones, and programs the enables through a small register bus using word addresses.

Three ordinary sets, numbered 1 to 3, are built by default. Set number 6 is the control set. Its enable word holds the global enable (bit 0) and the level mask (bit L for level L, L = 1..15). Its status word holds the vector in bits 3:0, the high flag in bit 8 and the low flag in bit 9. A word address is {set[3:0], kind[1:0]}, where kind 0 is status (read only), kind 1 is clear (write-one-to-clear, reads 0) and kind 2 is enable (read/write). Source (set s, bit b) is `src_evt[(s-1)*32+b]`. Pin p of `io_pin` adds a rising-edge event at set 3 bit 8+p and a falling-edge event at set 3 bit 16+p.

The bus front end is a two-state machine. BUS_IDLE raises `req_ready` and, on `req_valid`, performs the access and moves to BUS_RESP (transition "accept"). BUS_RESP raises `rsp_valid` with the read data for one cycle and always returns to BUS_IDLE (transition "complete").

Top module: `intr_ctrl_two_tier`

## Requirements
- R1: After reset all pending bits, per-set enables and the control enable word are 0, `irq_hi`, `irq_lo` and `irq_vec` are 0, and `req_ready` is 1.
- R2: A 0-to-1 transition on a source line sets its pending bit at the clock edge where the new level is first sampled. A line held high, including one held high through reset, does not set the bit again.
- R3: Writing a word to a set's clear location (kind 1) clears exactly the pending bits written as 1 and leaves the rest. Writes to a status location (kind 0) are ignored.
- R4: If a new edge and a clear of the same bit land on the same clock edge, the bit stays pending.
- R5: With the global enable set, `irq_lo` is 1 when some pending source that is not on the level table has its enable bit set.
- R6: Sources on the level table never drive `irq_lo`, and their per-bit enable bits have no effect.
- R7: Level table: set 3 bits 24 and 25 are level 15, set 3 bit 30 is 14, set 3 bit 29 is 13, set 2 bits 16 to 19 are all level 9, set 1 bits 18, 17 and 27 are levels 4, 3 and 2, and set 3 bits 8 and 16 are level 1.
- R8: A level takes part in encoding only while its mask bit (control enable bit L) is set.
- R9: With global enable (control enable bit 0) clear, neither request line asserts. `irq_vec` still shows the encoded level.
- R10: `irq_vec` equals the highest level that has a pending source and a set mask bit, or 0 if there is none. `irq_hi` is 1 when the global enable is set and the vector is nonzero.
- R11: The control status word (set 6, kind 0) returns the vector in bits 3:0, `irq_hi` in bit 8 and `irq_lo` in bit 9, with all other bits 0.
- R12: A rising edge of `io_pin[p]` sets set 3 bit 8+p, and a falling edge sets set 3 bit 16+p.
- R13: A request is accepted in BUS_IDLE. `rsp_valid` is high for exactly the next cycle, with `req_ready` low. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NSETS*32 | Source event lines, rising edge captured |
| io_pin | input | NIO | I/O pins, both edges captured separately |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address {set, kind} |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| irq_vec | output | 4 | Encoded winning level |

## Verification
The assertions assume that `req_valid` is raised only while the controller can take it, and that a request is dropped once its response appears. The bench's bus task keeps to this by holding each request for exactly one accepting edge and waiting for BUS_RESP to finish. The assertions also assume that source and pin levels change only away from the clock edge. Every source pulse and pin change in the bench is therefore driven on the falling clock edge and lasts at least one full cycle, so each edge is seen exactly once.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int WORD_W        = 32;
    localparam int LVL_W         = 4;
    localparam int NUM_LVL       = 15;
    localparam int CTL_SET       = 6;
    localparam int PIN_SET       = 3;
    localparam int PIN_RISE_BASE = 8;
    localparam int PIN_FALL_BASE = 16;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_ENABLE = 2'd2,
        REG_NONE   = 2'd3
    } reg_kind_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // Fixed level table (R7); 0 means the bit is an ordinary low source.
    function automatic logic [LVL_W-1:0] hi_level(input int set_no, input int bit_no);
        logic [LVL_W-1:0] lv;
        lv = '0;
        if (set_no == 3) begin
            if (bit_no == 24 || bit_no == 25)                          lv = 4'd15;
            else if (bit_no == 30)                                     lv = 4'd14;
            else if (bit_no == 29)                                     lv = 4'd13;
            else if (bit_no == PIN_RISE_BASE || bit_no == PIN_FALL_BASE) lv = 4'd1;
        end else if (set_no == 2) begin
            if (bit_no >= 16 && bit_no <= 19)                          lv = 4'd9;
        end else if (set_no == 1) begin
            if (bit_no == 18)                                          lv = 4'd4;
            else if (bit_no == 17)                                     lv = 4'd3;
            else if (bit_no == 27)                                     lv = 4'd2;
        end
        return lv;
    endfunction
endpackage

// File: rtl/ic_edge_det.sv
module ic_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // History resets high: a line already high at reset is not an event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ic_set_regs.sv
module ic_set_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_evt,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend,
    output logic [W-1:0] en
);
    logic [W-1:0] pend_q;
    logic [W-1:0] en_q;
    logic [W-1:0] clr_mask;

    assign clr_mask = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            // a fresh edge wins over a clear of the same bit
            pend_q <= (pend_q & ~clr_mask) | set_evt;
            if (en_we) en_q <= wdata;
        end
    end

    assign pend = pend_q;
    assign en   = en_q;
endmodule

// File: rtl/ic_prio_enc.sv
module ic_prio_enc
    import ic_pkg::*;
#(
    parameter int NSETS = 3,
    localparam int NBITS = NSETS * WORD_W
) (
    input  logic [NBITS-1:0]   pend,
    input  logic [NUM_LVL:1]   lvl_en,
    output logic [NUM_LVL:1]   act,
    output logic [LVL_W-1:0]   vec
);
    function automatic logic [NBITS-1:0] level_bits(input int lv);
        logic [NBITS-1:0] m;
        m = '0;
        for (int i = 0; i < NBITS; i++) begin
            if (int'(hi_level(i / WORD_W + 1, i % WORD_W)) == lv) m[i] = 1'b1;
        end
        return m;
    endfunction

    for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
        localparam logic [NBITS-1:0] LMAP = level_bits(l);
        assign act[l] = |(pend & LMAP);
    end

    always_comb begin
        vec = '0;
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (act[l] && lvl_en[l]) vec = LVL_W'(l);
        end
    end
endmodule

// File: rtl/ic_bus_fsm.sv
module ic_bus_fsm
    import ic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic rsp_valid,
    output logic accept
);
    bus_state_e state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            unique case (state_q)
                BUS_IDLE: if (req_valid) state_q <= BUS_RESP;
                BUS_RESP: state_q <= BUS_IDLE;
                default:  state_q <= BUS_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            BUS_IDLE: req_ready = 1'b1;
            BUS_RESP: rsp_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
        accept = req_valid & req_ready;
    end
endmodule

// File: rtl/intr_ctrl_two_tier.sv
module intr_ctrl_two_tier
    import ic_pkg::*;
#(
    parameter int NSETS = 3,
    parameter int NIO   = 4,
    localparam int NBITS = NSETS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NBITS-1:0]   src_evt,
    input  logic [NIO-1:0]     io_pin,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [5:0]         req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic               irq_hi,
    output logic               irq_lo,
    output logic [LVL_W-1:0]   irq_vec
);
    function automatic logic [NBITS-1:0] table_bits();
        logic [NBITS-1:0] m;
        m = '0;
        for (int i = 0; i < NBITS; i++) begin
            if (hi_level(i / WORD_W + 1, i % WORD_W) != '0) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NBITS-1:0] HI_MAP   = table_bits();
    localparam int               PIN_BASE = (PIN_SET - 1) * WORD_W;

    logic [NBITS-1:0]     src_rise, pin_place, set_evt_all;
    logic [2*NIO-1:0]     pin_edge;
    logic [NBITS-1:0]     pend_all, en_all;
    logic [NSETS-1:0]     clr_we, en_we;
    logic                 accept, wr_go, ctl_we;
    logic [3:0]           a_set;
    reg_kind_e            a_kind;
    logic [15:0]          ctl_en_q;
    logic [NUM_LVL:1]     act_w;
    logic [LVL_W-1:0]     vec_w;
    logic [WORD_W-1:0]    rd_mux, rdata_q, ctl_stat;

    ic_edge_det #(.W(NBITS)) u_src_edge (
        .clk(clk), .rst_n(rst_n), .lvl(src_evt), .rise(src_rise)
    );

    ic_edge_det #(.W(2*NIO)) u_pin_edge (
        .clk(clk), .rst_n(rst_n), .lvl({~io_pin, io_pin}), .rise(pin_edge)
    );

    // R12: pin edges land on fixed bits of the pin set
    always_comb begin
        pin_place = '0;
        for (int p = 0; p < NIO; p++) begin
            pin_place[PIN_BASE + PIN_RISE_BASE + p] = pin_edge[p];
            pin_place[PIN_BASE + PIN_FALL_BASE + p] = pin_edge[NIO + p];
        end
    end

    assign set_evt_all = src_rise | pin_place;

    ic_bus_fsm u_bus (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .accept(accept)
    );

    assign a_set  = req_addr[5:2];
    assign a_kind = reg_kind_e'(req_addr[1:0]);
    assign wr_go  = accept & req_write;
    assign ctl_we = wr_go && (a_set == 4'(CTL_SET)) && (a_kind == REG_ENABLE);

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        assign clr_we[s] = wr_go && (a_set == 4'(s + 1)) && (a_kind == REG_CLEAR);
        assign en_we[s]  = wr_go && (a_set == 4'(s + 1)) && (a_kind == REG_ENABLE);

        ic_set_regs #(.W(WORD_W)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .set_evt(set_evt_all[s*WORD_W +: WORD_W]),
            .clr_we(clr_we[s]), .en_we(en_we[s]),
            .wdata(req_wdata),
            .pend(pend_all[s*WORD_W +: WORD_W]),
            .en(en_all[s*WORD_W +: WORD_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_en_q <= '0;
        else if (ctl_we) ctl_en_q <= req_wdata[15:0];
    end

    ic_prio_enc #(.NSETS(NSETS)) u_enc (
        .pend(pend_all), .lvl_en(ctl_en_q[NUM_LVL:1]), .act(act_w), .vec(vec_w)
    );

    assign irq_vec = vec_w;
    assign irq_hi  = ctl_en_q[0] & (vec_w != '0);
    assign irq_lo  = ctl_en_q[0] & (|(pend_all & en_all & ~HI_MAP));

    assign ctl_stat = {22'd0, irq_lo, irq_hi, 4'd0, vec_w};

    always_comb begin
        rd_mux = '0;
        for (int s = 0; s < NSETS; s++) begin
            if (a_set == 4'(s + 1)) begin
                if (a_kind == REG_STATUS) rd_mux = pend_all[s*WORD_W +: WORD_W];
                if (a_kind == REG_ENABLE) rd_mux = en_all[s*WORD_W +: WORD_W];
            end
        end
        if (a_set == 4'(CTL_SET)) begin
            if (a_kind == REG_STATUS) rd_mux = ctl_stat;
            if (a_kind == REG_ENABLE) rd_mux = {16'd0, ctl_en_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (accept) rdata_q <= req_write ? '0 : rd_mux;
    end

    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/ic_chk.sv
module ic_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ctl_en,
    input logic [15:0] act,
    input logic        irq_hi,
    input logic        irq_lo,
    input logic [3:0]  irq_vec,
    input logic        req_ready,
    input logic        rsp_valid
);
    // R9
    no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en[0] |-> (!irq_hi && !irq_lo));

    // R8
    vec_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec != 4'd0) |-> ctl_en[irq_vec]);

    // R10
    vec_level_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec != 4'd0) |-> act[irq_vec]);

    // R13
    resp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R13
    resp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind intr_ctrl_two_tier ic_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en_q), .act({act_w, 1'b0}),
    .irq_hi(irq_hi), .irq_lo(irq_lo), .irq_vec(irq_vec),
    .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/intr_ctrl_two_tier_bench.sv
module intr_ctrl_two_tier_bench;
    localparam int NSETS = 3;
    localparam int NIO   = 4;
    localparam int NROWS = 43;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_PIN = 2'd3;

    // {op, addr, data, expected read, expected {hi,lo,vec}, requirement}
    localparam logic [81:0] TBL [NROWS] = '{
        {OP_RD,  6'h18, 32'h0,        32'h0,     6'h00, 4'd1},  // R1
        {OP_RD,  6'h06, 32'h0,        32'h0,     6'h00, 4'd1},  // R1
        {OP_EV,  6'h00, 32'd5,        32'h0,     6'h00, 4'd2},  // R2
        {OP_RD,  6'h04, 32'h0,        32'h20,    6'h00, 4'd2},  // R2 bit0 held high from reset
        {OP_WR,  6'h06, 32'h20,       32'h0,     6'h00, 4'd9},  // R9
        {OP_WR,  6'h1A, 32'h1,        32'h0,     6'h10, 4'd5},  // R5
        {OP_RD,  6'h18, 32'h0,        32'h200,   6'h10, 4'd11}, // R11
        {OP_WR,  6'h05, 32'h10,       32'h0,     6'h10, 4'd3},  // R3
        {OP_WR,  6'h04, 32'hFFFFFFFF, 32'h0,     6'h10, 4'd3},  // R3
        {OP_RD,  6'h04, 32'h0,        32'h20,    6'h10, 4'd3},  // R3
        {OP_WR,  6'h05, 32'h20,       32'h0,     6'h00, 4'd3},  // R3
        {OP_EV,  6'h00, 32'd18,       32'h0,     6'h00, 4'd8},  // R8
        {OP_WR,  6'h06, 32'h40000,    32'h0,     6'h00, 4'd6},  // R6
        {OP_WR,  6'h1A, 32'h11,       32'h0,     6'h24, 4'd8},  // R8
        {OP_EV,  6'h00, 32'd49,       32'h0,     6'h24, 4'd8},  // R8
        {OP_WR,  6'h1A, 32'h211,      32'h0,     6'h29, 4'd10}, // R10
        {OP_EV,  6'h00, 32'd94,       32'h0,     6'h29, 4'd8},  // R8
        {OP_WR,  6'h1A, 32'hFFFF,     32'h0,     6'h2E, 4'd7},  // R7
        {OP_EV,  6'h00, 32'd89,       32'h0,     6'h2F, 4'd7},  // R7
        {OP_RD,  6'h18, 32'h0,        32'h10F,   6'h2F, 4'd11}, // R11
        {OP_WR,  6'h1A, 32'hFFFE,     32'h0,     6'h0F, 4'd9},  // R9
        {OP_WR,  6'h1A, 32'hFFFF,     32'h0,     6'h2F, 4'd9},  // R9
        {OP_WR,  6'h0D, 32'h42000000, 32'h0,     6'h29, 4'd10}, // R10
        {OP_WR,  6'h09, 32'h00020000, 32'h0,     6'h24, 4'd10}, // R10
        {OP_WR,  6'h05, 32'h00040000, 32'h0,     6'h00, 4'd10}, // R10
        {OP_PIN, 6'h00, 32'h1,        32'h0,     6'h21, 4'd12}, // R12
        {OP_RD,  6'h0C, 32'h0,        32'h100,   6'h21, 4'd12}, // R12
        {OP_WR,  6'h0D, 32'h100,      32'h0,     6'h00, 4'd12}, // R12
        {OP_PIN, 6'h00, 32'h0,        32'h0,     6'h21, 4'd12}, // R12
        {OP_RD,  6'h0C, 32'h0,        32'h10000, 6'h21, 4'd12}, // R12
        {OP_WR,  6'h0D, 32'h10000,    32'h0,     6'h00, 4'd12}, // R12
        {OP_EV,  6'h00, 32'd93,       32'h0,     6'h2D, 4'd7},  // R7
        {OP_WR,  6'h0D, 32'h20000000, 32'h0,     6'h00, 4'd7},  // R7
        {OP_EV,  6'h00, 32'd88,       32'h0,     6'h2F, 4'd7},  // R7
        {OP_WR,  6'h0D, 32'h01000000, 32'h0,     6'h00, 4'd7},  // R7
        {OP_EV,  6'h00, 32'd27,       32'h0,     6'h22, 4'd7},  // R7
        {OP_WR,  6'h05, 32'h08000000, 32'h0,     6'h00, 4'd7},  // R7
        {OP_EV,  6'h00, 32'd17,       32'h0,     6'h23, 4'd7},  // R7
        {OP_WR,  6'h05, 32'h00020000, 32'h0,     6'h00, 4'd7},  // R7
        {OP_RD,  6'h3C, 32'h0,        32'h0,     6'h00, 4'd13}, // R13
        {OP_WR,  6'h3E, 32'h1234,     32'h0,     6'h00, 4'd13}, // R13
        {OP_RD,  6'h1A, 32'h0,        32'hFFFF,  6'h00, 4'd13}, // R13
        {OP_RD,  6'h0E, 32'h0,        32'h0,     6'h00, 4'd1}   // R1
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NSETS*32-1:0]   src_evt = '0;
    logic [NIO-1:0]        io_pin = '0;
    logic                  req_valid = 1'b0;
    logic                  req_write = 1'b0;
    logic [5:0]            req_addr = '0;
    logic [31:0]           req_wdata = '0;
    logic                  req_ready, rsp_valid, irq_hi, irq_lo;
    logic [31:0]           rsp_rdata;
    logic [3:0]            irq_vec;
    int                    n_checks = 0;
    int                    n_fail = 0;
    logic                  hs_ok;
    logic                  done = 1'b0;

    always #5 clk = ~clk;

    intr_ctrl_two_tier #(.NSETS(NSETS), .NIO(NIO)) u_intr_ctrl_two_tier (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .io_pin(io_pin),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .irq_hi(irq_hi), .irq_lo(irq_lo), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [5:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        hs_ok = rsp_valid && !req_ready;
        @(posedge clk);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); src_evt[idx] = 1'b1;
        @(posedge clk);
        @(negedge clk); src_evt[idx] = 1'b0;
        @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        src_evt[0] = 1'b1;            // R2: held high through reset
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 outputs", {26'd0, irq_hi, irq_lo, irq_vec}, 32'h0);
        check("R1 ready", {31'd0, req_ready}, 32'h1);

        for (int k = 0; k < NROWS; k++) begin
            logic [81:0] row;
            string tag;
            row = TBL[k];
            tag = $sformatf("R%0d row%0d", row[3:0], k);
            unique case (row[81:80])
                OP_WR:  bus(1'b1, row[79:74], row[73:42], rd);
                OP_RD:  begin
                    bus(1'b0, row[79:74], row[73:42], rd);
                    check({tag, " rdata"}, rd, row[41:10]);
                end
                OP_EV:  pulse(int'(row[48:42]));
                OP_PIN: begin
                    @(negedge clk); io_pin = row[42 +: NIO];
                    @(posedge clk);
                end
                default: ;
            endcase
            @(negedge clk);
            check({tag, " irq"}, {26'd0, irq_hi, irq_lo, irq_vec}, {26'd0, row[9:4]});
        end

        // R13: response cycle had rsp_valid high and ready low
        check("R13 handshake", {31'd0, hs_ok}, 32'h1);

        // R4: edge on bit5 lands on the same edge as its clear
        pulse(5);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h05; req_wdata = 32'h20;
        src_evt[5] = 1'b1;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk);
        bus(1'b0, 6'h04, 32'h0, rd);
        check("R4 set beats clear", rd, 32'h20);

        // R2: line still high, a clear is not undone by it
        bus(1'b1, 6'h05, 32'h20, rd);
        repeat (3) @(posedge clk);
        bus(1'b0, 6'h04, 32'h0, rd);
        check("R2 steady high no re-set", rd, 32'h0);
        @(negedge clk) src_evt[5] = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule